// File: doc/BRIEF.md
# Host-side IEEE 1284 parallel port engine

This block runs the host end of a parallel printer-style link in two operating modes. In the plain Centronics-style mode it pushes bytes to a peripheral. It waits for the peripheral to be ready, then sends a timed strobe, then waits for the acknowledge pulse. When the CPU asks for the extended mode, the block runs a short negotiation and records whether the peripheral accepted. If it did, the block moves into ECP operation.

In ECP operation the block sends forward bytes, each tagged as a command or as data, and paces them with the peripheral's Busy line. It can also turn the bus around and collect reverse bytes. Each reverse byte comes with a ninth bit that tells a command from data. The host releases the data bus before a reverse phase. It drives the bus again only after the peripheral's PError line shows that the turnaround back to forward is done.

Toward the CPU the block takes a byte, a command flag, start and direction requests and a mode request. It returns status bits, a received byte and an interrupt for peripheral service requests. Every handshake wait is limited by a programmable timeout. Link bit 0 carries the CPU byte's bit 7, so the bus is bit-reversed relative to the CPU.

Top module: `pp1284_host`

## Requirements
- R1: Reset gives Compatible idle: n_strobe, n_autofd and n_init high, n_selectin low, pd_oe high, and ecp_on, neg_ok, tmo and eng_busy all low.
- R2: In Compatible mode, a start request while busy_in is high produces no strobe until busy_in goes low.
- R3: A Compatible strobe stays low for exactly STB_W clocks. During the strobe, pd_out equals the CPU byte with bit i on pin 7-i. The same value is on pd_out at least one clock before the strobe falls and still one clock after it rises.
- R4: A Compatible transfer stays busy after the strobe until n_ack has gone low and then high again, and then it ends with eng_busy low.
- R5: st_online, st_fault, st_paper and st_busy follow select_in, the inverse of n_fault, perror_in and busy_in, one clock late.
- R6: A rising cpu_ecp_req in Compatible idle starts negotiation. The block drives n_selectin high and n_autofd low and puts the extensibility byte 0x10, bit-reversed, on pd_out. When n_ack goes low it latches select_in into neg_ok. When n_ack returns high it enters ECP if neg_ok is 1, and otherwise goes back to Compatible idle with n_selectin low.
- R7: While ecp_on is high, n_selectin is high. Dropping cpu_ecp_req in ECP idle drives n_selectin low, clears ecp_on and returns to Compatible operation.
- R8: In an ECP forward transfer, n_strobe goes low with the bit-reversed byte on pd_out, and n_autofd is low exactly when cpu_cmd was 1. The strobe rises after busy_in goes high, and the transfer ends after busy_in goes low.
- R9: A reverse request drives n_init and n_autofd low and drops pd_oe. pd_oe stays low until perror_in is high again after the CPU withdraws cpu_rev.
- R10: In the reverse phase, n_autofd low means the host is ready. When n_ack goes low, the block captures the bit-reversed pd_in into rx_byte and sets rx_cmd to the inverse of busy_in (busy_in low marks a command). It pulses rx_valid for one clock and raises n_autofd. n_autofd goes low again after n_ack rises.
- R11: irq is high exactly while ecp_on is high and n_fault is low, in both directions. It stays low in Compatible mode.
- R12: A handshake wait that runs past to_limit clocks sets tmo and returns the engine to the idle state of the current mode with n_strobe high. tmo clears when the next transfer or negotiation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_byte | input | DW | Byte to send |
| cpu_cmd | input | 1 | ECP forward byte is a command |
| cpu_go | input | 1 | Start a forward transfer (one clock) |
| cpu_rev | input | 1 | Hold high for ECP reverse direction |
| cpu_ecp_req | input | 1 | Request ECP mode (rise) / leave it (fall) |
| to_limit | input | TO_W | Handshake timeout in clocks |
| eng_busy | output | 1 | Engine in a transfer or handshake |
| ecp_on | output | 1 | Link is in ECP mode |
| neg_ok | output | 1 | Result of last negotiation |
| tmo | output | 1 | Last handshake timed out |
| irq | output | 1 | Peripheral service request in ECP |
| st_online | output | 1 | Peripheral on-line |
| st_fault | output | 1 | Peripheral error |
| st_paper | output | 1 | Paper-path error |
| st_busy | output | 1 | Peripheral busy |
| rx_byte | output | DW | Last reverse byte |
| rx_cmd | output | 1 | Last reverse byte was a command |
| rx_valid | output | 1 | One-clock pulse: new reverse byte |
| n_strobe | output | 1 | Link strobe, active low |
| n_autofd | output | 1 | Link auto-feed / host handshake, active low |
| n_init | output | 1 | Link init / reverse request, active low |
| n_selectin | output | 1 | Link select-in, active low |
| n_ack | input | 1 | Peripheral acknowledge, active low |
| busy_in | input | 1 | Peripheral busy / ninth bit |
| perror_in | input | 1 | Peripheral paper error / turnaround ack |
| select_in | input | 1 | Peripheral selected |
| n_fault | input | 1 | Peripheral fault / request, active low |
| pd_out | output | DW | Data bus value driven by host |
| pd_in | input | DW | Data bus value sampled from link |
| pd_oe | output | 1 | Host drives the data bus |

## Verification
The assertions assume a peripheral that follows the handshakes in order. It pulls n_ack low only when a byte or negotiation is pending. It moves perror_in only around a turnaround, and it changes pd_in and busy_in no later than its n_ack edge in the reverse phase. The bench's peripheral model drives every link input on the falling clock edge, one step at a time, and waits for the host's response before the next step. The timeout cases are the only ones where the model deliberately stays silent.

// File: rtl/pp1284_pkg.sv
package pp1284_pkg;
  typedef enum logic [4:0] {
    S_CIDLE, S_CWAIT, S_CSETUP, S_CSTROBE, S_CHOLD, S_CACK, S_CACKH,
    S_NREQ, S_NACKH,
    S_EIDLE, S_EFWD, S_EFWDH, S_ETURN, S_RIDLE, S_RACKH, S_EBACK, S_EXIT
  } pp_state_t;

  localparam logic [7:0] PP_XBYTE_ECP = 8'h10;
endpackage

// File: rtl/pp_bitrev.sv
module pp_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign y[i] = a[W-1-i];
  end
endmodule

// File: rtl/pp_wait_timer.sv
module pp_wait_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt != limit) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit);
endmodule

// File: rtl/pp1284_host.sv
module pp1284_host
  import pp1284_pkg::*;
#(
  parameter int DW    = 8,
  parameter int STB_W = 3,
  parameter int TO_W  = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   cpu_byte,
  input  logic            cpu_cmd,
  input  logic            cpu_go,
  input  logic            cpu_rev,
  input  logic            cpu_ecp_req,
  input  logic [TO_W-1:0] to_limit,
  output logic            eng_busy,
  output logic            ecp_on,
  output logic            neg_ok,
  output logic            tmo,
  output logic            irq,
  output logic            st_online,
  output logic            st_fault,
  output logic            st_paper,
  output logic            st_busy,
  output logic [DW-1:0]   rx_byte,
  output logic            rx_cmd,
  output logic            rx_valid,
  output logic            n_strobe,
  output logic            n_autofd,
  output logic            n_init,
  output logic            n_selectin,
  input  logic            n_ack,
  input  logic            busy_in,
  input  logic            perror_in,
  input  logic            select_in,
  input  logic            n_fault,
  output logic [DW-1:0]   pd_out,
  input  logic [DW-1:0]   pd_in,
  output logic            pd_oe
);
  localparam int SCW = $clog2(STB_W + 1);

  pp_state_t      st, st_nxt;
  logic           r_ack_n, r_busy, r_perr, r_sel, r_fault_n, mode_q;
  logic [DW-1:0]  r_pd, tx_byte, pd_rev;
  logic           tx_cmd;
  logic [SCW-1:0] scnt;
  logic           waiting, t_exp, t_restart;
  logic           ld_go, ld_ext, cap, timeout_hit, clr_tmo;

  // input capture stage
  always_ff @(posedge clk) begin
    if (rst) begin
      r_ack_n <= 1'b1; r_busy <= 1'b0; r_perr <= 1'b0;
      r_sel <= 1'b0; r_fault_n <= 1'b1; r_pd <= '0; mode_q <= 1'b0;
    end else begin
      r_ack_n <= n_ack; r_busy <= busy_in; r_perr <= perror_in;
      r_sel <= select_in; r_fault_n <= n_fault; r_pd <= pd_in;
      mode_q <= cpu_ecp_req;
    end
  end

  assign st_online = r_sel;
  assign st_fault  = ~r_fault_n;
  assign st_paper  = r_perr;
  assign st_busy   = r_busy;
  assign irq       = ecp_on & ~r_fault_n;

  pp_bitrev #(.W(DW)) u_txrev (.a(tx_byte), .y(pd_out));
  pp_bitrev #(.W(DW)) u_rxrev (.a(r_pd),    .y(pd_rev));

  assign waiting = st inside {S_CWAIT, S_CACK, S_CACKH, S_NREQ, S_NACKH,
                              S_EFWD, S_EFWDH, S_ETURN, S_RACKH, S_EBACK};
  assign t_restart = (st_nxt != st) || !waiting;

  pp_wait_timer #(.W(TO_W)) u_tmr (
    .clk(clk), .rst(rst), .restart(t_restart), .limit(to_limit), .expired(t_exp)
  );

  always_comb begin
    st_nxt = st; ld_go = 1'b0; ld_ext = 1'b0; cap = 1'b0; timeout_hit = 1'b0;
    case (st)
      S_CIDLE:   if (cpu_ecp_req && !mode_q) begin st_nxt = S_NREQ; ld_ext = 1'b1; end
                 else if (cpu_go) begin st_nxt = S_CWAIT; ld_go = 1'b1; end
      S_CWAIT:   if (!r_busy) st_nxt = S_CSETUP;
      S_CSETUP:  st_nxt = S_CSTROBE;
      S_CSTROBE: if (scnt == SCW'(STB_W - 1)) st_nxt = S_CHOLD;
      S_CHOLD:   st_nxt = S_CACK;
      S_CACK:    if (!r_ack_n) st_nxt = S_CACKH;
      S_CACKH:   if (r_ack_n) st_nxt = S_CIDLE;
      S_NREQ:    if (!r_ack_n) st_nxt = S_NACKH;
      S_NACKH:   if (r_ack_n) st_nxt = neg_ok ? S_EIDLE : S_CIDLE;
      S_EIDLE:   if (!cpu_ecp_req) st_nxt = S_EXIT;
                 else if (cpu_go) begin st_nxt = S_EFWD; ld_go = 1'b1; end
                 else if (cpu_rev) st_nxt = S_ETURN;
      S_EFWD:    if (r_busy) st_nxt = S_EFWDH;
      S_EFWDH:   if (!r_busy) st_nxt = S_EIDLE;
      S_ETURN:   if (!r_perr) st_nxt = S_RIDLE;
      S_RIDLE:   if (!cpu_rev) st_nxt = S_EBACK;
                 else if (!r_ack_n) begin st_nxt = S_RACKH; cap = 1'b1; end
      S_RACKH:   if (r_ack_n) st_nxt = S_RIDLE;
      S_EBACK:   if (r_perr) st_nxt = S_EIDLE;
      S_EXIT:    st_nxt = S_CIDLE;
      default:   st_nxt = S_CIDLE;
    endcase
    if (waiting && t_exp && st_nxt == st) begin
      timeout_hit = 1'b1;
      st_nxt = ecp_on ? S_EIDLE : S_CIDLE;
    end
  end

  assign clr_tmo = ld_go || ld_ext || (st == S_EIDLE && st_nxt == S_ETURN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_CIDLE; scnt <= '0; tx_byte <= '0; tx_cmd <= 1'b0;
      neg_ok <= 1'b0; ecp_on <= 1'b0; tmo <= 1'b0;
      rx_byte <= '0; rx_cmd <= 1'b0; rx_valid <= 1'b0;
    end else begin
      st <= st_nxt;
      scnt <= (st == S_CSTROBE) ? scnt + 1'b1 : '0;
      if (ld_go) begin tx_byte <= cpu_byte; tx_cmd <= cpu_cmd; end
      else if (ld_ext) begin tx_byte <= DW'(PP_XBYTE_ECP); tx_cmd <= 1'b0; end
      if (st == S_NREQ && st_nxt == S_NACKH) neg_ok <= r_sel;
      if (st == S_NACKH && st_nxt == S_EIDLE) ecp_on <= 1'b1;
      else if (st_nxt == S_EXIT) ecp_on <= 1'b0;
      if (timeout_hit) tmo <= 1'b1;
      else if (clr_tmo) tmo <= 1'b0;
      rx_valid <= cap;
      if (cap) begin rx_byte <= pd_rev; rx_cmd <= ~r_busy; end
    end
  end

  // link controls decoded from the state register
  always_comb begin
    n_strobe = 1'b1; n_autofd = 1'b1; n_init = 1'b1; n_selectin = 1'b1; pd_oe = 1'b1;
    case (st)
      S_CIDLE, S_CWAIT, S_CSETUP, S_CHOLD, S_CACK, S_CACKH, S_EXIT: n_selectin = 1'b0;
      S_CSTROBE: begin n_selectin = 1'b0; n_strobe = 1'b0; end
      S_NREQ:    n_autofd = 1'b0;
      S_EFWD:    begin n_strobe = 1'b0; n_autofd = ~tx_cmd; end
      S_ETURN, S_RIDLE: begin n_autofd = 1'b0; n_init = 1'b0; pd_oe = 1'b0; end
      S_RACKH:   begin n_init = 1'b0; pd_oe = 1'b0; end
      S_EBACK:   pd_oe = r_perr;
      default:   ;
    endcase
  end

  assign eng_busy = !(st inside {S_CIDLE, S_EIDLE, S_RIDLE});
endmodule

// File: rtl/pp1284_host_chk.sv
module pp1284_host_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          n_strobe,
  input logic          n_selectin,
  input logic          n_init,
  input logic          pd_oe,
  input logic [DW-1:0] pd_out,
  input logic          ecp_on,
  input logic          eng_busy,
  input logic          tmo,
  input logic          irq,
  input logic          rx_valid,
  input logic          st_paper
);
  p_setup_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(n_strobe) && !ecp_on) |-> $stable(pd_out));

  p_sel_high_ecp_r7: assert property (@(posedge clk) disable iff (rst)
    ecp_on |-> n_selectin);

  p_idle_select_r7: assert property (@(posedge clk) disable iff (rst)
    (!ecp_on && !eng_busy) |-> !n_selectin);

  p_release_bus_r9: assert property (@(posedge clk) disable iff (rst)
    !n_init |-> !pd_oe);

  p_oe_after_perr_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(pd_oe) && !tmo) |-> st_paper);

  p_rx_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_irq_ecp_only_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> ecp_on);

  p_timeout_idle_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo) |-> (!eng_busy && n_strobe));
endmodule

bind pp1284_host pp1284_host_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .n_strobe(n_strobe), .n_selectin(n_selectin),
  .n_init(n_init), .pd_oe(pd_oe), .pd_out(pd_out), .ecp_on(ecp_on),
  .eng_busy(eng_busy), .tmo(tmo), .irq(irq), .rx_valid(rx_valid),
  .st_paper(st_paper)
);

// File: tb/sim_pp1284_host.sv
module sim_pp1284_host;
  localparam int DW = 8;
  localparam int STB_W = 3;
  localparam int TO_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] cpu_byte = '0, rx_byte, pd_out, pd_in = '0;
  logic cpu_cmd = 0, cpu_go = 0, cpu_rev = 0, cpu_ecp_req = 0;
  logic [TO_W-1:0] to_limit = 8'd40;
  logic eng_busy, ecp_on, neg_ok, tmo, irq, st_online, st_fault, st_paper, st_busy;
  logic rx_cmd, rx_valid, n_strobe, n_autofd, n_init, n_selectin, pd_oe;
  logic n_ack = 1, busy_in = 0, perror_in = 1, select_in = 1, n_fault = 1;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pp1284_host #(.DW(DW), .STB_W(STB_W), .TO_W(TO_W)) u0 (
    .clk(clk), .rst(rst), .cpu_byte(cpu_byte), .cpu_cmd(cpu_cmd), .cpu_go(cpu_go),
    .cpu_rev(cpu_rev), .cpu_ecp_req(cpu_ecp_req), .to_limit(to_limit),
    .eng_busy(eng_busy), .ecp_on(ecp_on), .neg_ok(neg_ok), .tmo(tmo), .irq(irq),
    .st_online(st_online), .st_fault(st_fault), .st_paper(st_paper), .st_busy(st_busy),
    .rx_byte(rx_byte), .rx_cmd(rx_cmd), .rx_valid(rx_valid),
    .n_strobe(n_strobe), .n_autofd(n_autofd), .n_init(n_init), .n_selectin(n_selectin),
    .n_ack(n_ack), .busy_in(busy_in), .perror_in(perror_in), .select_in(select_in),
    .n_fault(n_fault), .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse();
    n_ack = 0; cyc(3); n_ack = 1;
  endtask

  task automatic compat_send(input logic [7:0] b, input int hold);
    int w;
    int lw;
    cpu_byte = b; cpu_go = 1; busy_in = (hold > 0);
    cyc(1); cpu_go = 0;
    if (hold > 0) begin
      cyc(hold);
      chk("R2 no strobe while busy", {31'd0, n_strobe}, 32'd1);
      busy_in = 0;
    end
    w = 0;
    while (n_strobe && w < 50) begin cyc(1); w++; end
    chk("R3 data during strobe", {24'd0, pd_out}, {24'd0, rev8(b)});
    lw = 0;
    while (!n_strobe && lw < 50) begin lw++; cyc(1); end
    chk("R3 strobe width", lw, STB_W);
    chk("R3 data hold", {24'd0, pd_out}, {24'd0, rev8(b)});
    cyc(2);
    chk("R4 busy until ack", {31'd0, eng_busy}, 32'd1);
    ack_pulse(); cyc(4);
    chk("R4 done after ack", {31'd0, eng_busy}, 32'd0);
  endtask

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R1 reset state
    chk("R1 reset outputs",
        {23'd0, n_strobe, n_autofd, n_init, n_selectin, pd_oe, ecp_on, neg_ok, tmo, eng_busy},
        {23'd0, 9'b111010000});

    // R2/R3/R4 sweep
    for (int i = 0; i < 16; i++) compat_send(8'(i * 37 + 1), i % 4);
    compat_send(8'h80, 0);
    compat_send(8'h01, 2);

    // R5 status sweep, R11 irq silent in compatible mode
    for (int k = 0; k < 16; k++) begin
      select_in = k[0]; n_fault = k[1]; perror_in = k[2]; busy_in = k[3];
      cyc(2);
      chk("R5 status bits", {28'd0, st_online, st_fault, st_paper, st_busy},
          {28'd0, k[0], ~k[1], k[2], k[3]});
      chk("R11 no irq in compatible", {31'd0, irq}, 32'd0);
    end
    select_in = 1; n_fault = 1; perror_in = 1; busy_in = 0; cyc(2);

    // R12 compatible timeout
    busy_in = 1; cpu_byte = 8'h3C; cpu_go = 1; cyc(1); cpu_go = 0;
    cyc(60);
    chk("R12 timeout flag", {30'd0, tmo, eng_busy}, {30'd0, 2'b10});
    chk("R12 strobe idle", {31'd0, n_strobe}, 32'd1);
    busy_in = 0; cyc(2);
    compat_send(8'hA5, 0);
    chk("R12 tmo cleared", {31'd0, tmo}, 32'd0);

    // R6 refused negotiation
    select_in = 0; cpu_ecp_req = 1; cyc(3);
    chk("R6 negotiation lines", {30'd0, n_selectin, n_autofd}, {30'd0, 2'b10});
    chk("R6 extensibility byte", {24'd0, pd_out}, {24'd0, rev8(8'h10)});
    ack_pulse(); cyc(4);
    chk("R6 refused", {29'd0, neg_ok, ecp_on, n_selectin}, 32'd0);
    cpu_ecp_req = 0; cyc(2);

    // R6/R7 accepted negotiation
    select_in = 1; cpu_ecp_req = 1; cyc(3); ack_pulse(); cyc(4);
    chk("R6 accepted", {30'd0, neg_ok, ecp_on}, {30'd0, 2'b11});
    chk("R7 select-in high in ECP", {31'd0, n_selectin}, 32'd1);

    // R11 irq
    n_fault = 0; cyc(3);
    chk("R11 irq on request", {31'd0, irq}, 32'd1);
    n_fault = 1; cyc(3);
    chk("R11 irq off", {31'd0, irq}, 32'd0);

    // R8 forward sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'(i * 53 + 7);
      cpu_byte = b; cpu_cmd = i[0]; cpu_go = 1; cyc(1); cpu_go = 0; cyc(1);
      chk("R8 strobe and tag", {30'd0, n_strobe, n_autofd}, {30'd0, 1'b0, ~i[0]});
      chk("R8 forward data", {24'd0, pd_out}, {24'd0, rev8(b)});
      busy_in = 1; cyc(3);
      chk("R8 strobe released on busy", {31'd0, n_strobe}, 32'd1);
      busy_in = 0; cyc(3);
      chk("R8 forward done", {31'd0, eng_busy}, 32'd0);
    end
    cpu_cmd = 0;

    // R9 turnaround
    cpu_rev = 1; cyc(2);
    chk("R9 release bus", {29'd0, n_init, pd_oe, eng_busy}, {29'd0, 3'b001});
    perror_in = 0; cyc(3);
    chk("R10 host ready", {30'd0, eng_busy, n_autofd}, 32'd0);

    // R10 reverse sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      bit seen;
      d = 8'(i * 29 + 3);
      pd_in = d; busy_in = i[0]; n_ack = 0;
      seen = 0;
      for (int k = 0; k < 6; k++) begin
        cyc(1);
        if (rx_valid) begin seen = 1; break; end
      end
      chk("R10 rx_valid seen", {31'd0, seen}, 32'd1);
      chk("R10 rx byte", {23'd0, rx_cmd, rx_byte}, {23'd0, ~i[0], rev8(d)});
      chk("R10 autofd raised", {31'd0, n_autofd}, 32'd1);
      cyc(1);
      chk("R10 single pulse", {31'd0, rx_valid}, 32'd0);
      n_ack = 1; cyc(3);
      chk("R10 autofd ready again", {31'd0, n_autofd}, 32'd0);
    end
    busy_in = 0;

    cpu_rev = 0; cyc(3);
    chk("R9 wait for perror", {30'd0, n_init, pd_oe}, {30'd0, 2'b10});
    perror_in = 1; cyc(2);
    chk("R9 drive after perror", {31'd0, pd_oe}, 32'd1);
    cyc(2);
    chk("R9 back to forward idle", {31'd0, eng_busy}, 32'd0);

    // R12 ECP timeout
    cpu_byte = 8'h77; cpu_go = 1; cyc(1); cpu_go = 0; cyc(60);
    chk("R12 ECP timeout", {29'd0, tmo, ecp_on, n_strobe}, {29'd0, 3'b111});

    // R7 exit, R11 irq after exit
    n_fault = 0; cpu_ecp_req = 0; cyc(4);
    chk("R7 exit", {29'd0, ecp_on, n_selectin, irq}, 32'd0);
    n_fault = 1; cyc(2);
    compat_send(8'hC3, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule